// File: doc/BRIEF.md
# Two-Requester Alternating-Priority Arbiter

The block arbitrates between two single-bit requesters, `req_x` and `req_y`, and reports the winner on a two-bit grant code. When only one requester is active it always wins. When both are active, a one-bit priority state decides the winner. Granting a requester hands priority to the other one, so under a sustained tie the grants alternate and neither side is starved.

The grant is a combinational (Mealy) function of the priority state and both requests. The output decode and the next-state logic are kept in separate modules, because the output table is the same in both states except for the tie entry. When neither requester is active, the grant is 0 and the state is left as it is. The priority state is held in one flip-flop with an active-low asynchronous reset.

Top module: `alt_prio_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the priority state favours `req_y`. A tie seen first after reset yields grant code 1.
- R2: With `req_x`=0 and `req_y`=0 the grant is 0, and the priority state is kept: the next tie resolves as it would have without the idle cycle.
- R3: With `req_x`=0 and `req_y`=1 the grant is 1, whatever the state.
- R4: With `req_x`=1 and `req_y`=0 the grant is 2, whatever the state.
- R5: With both requests high in the state that favours `req_y`, the grant is 1.
- R6: With both requests high in the state that favours `req_x`, the grant is 2.
- R7: After a cycle with grant 1, the state favours `req_x`. After a cycle with grant 2, the state favours `req_y`.
- R8: The grant never takes the value 3.
- R9: With both requests held high for many cycles, the grant runs 1, 2, 1, 2 and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously |
| req_x | input | 1 | Request from requester X (granted as code 2) |
| req_y | input | 1 | Request from requester Y (granted as code 1) |
| grant | output | 2 | 0 no grant, 1 requester Y, 2 requester X |

## Verification
The hardest behaviour to reach from the ports is that a single-requester grant also moves the priority state. Its effect shows only at the next tie, possibly after idle cycles in between. The vector table therefore places ties after lone requests and after idle cycles, so that each state is reached by every kind of path. A reset applied in the middle of a run, with the state favouring `req_x`, checks that the state returns to favouring `req_y`. A long run of ties checks that the grants keep alternating.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int GRANT_W = 2;

  typedef enum logic {
    FAV_Y = 1'b0,
    FAV_X = 1'b1
  } fav_e;

  localparam logic [GRANT_W-1:0] GNT_NONE = 2'd0;
  localparam logic [GRANT_W-1:0] GNT_Y    = 2'd1;
  localparam logic [GRANT_W-1:0] GNT_X    = 2'd2;
endpackage

// File: rtl/arb_grant_decode.sv
module arb_grant_decode
  import arb_pkg::*;
(
  input  fav_e               fav,
  input  logic               req_x,
  input  logic               req_y,
  output logic [GRANT_W-1:0] grant
);
  always_comb begin
    unique case ({req_x, req_y})
      2'b00:   grant = GNT_NONE;
      2'b01:   grant = GNT_Y;
      2'b10:   grant = GNT_X;
      default: grant = (fav == FAV_X) ? GNT_X : GNT_Y;
    endcase
  end
endmodule

// File: rtl/arb_next_state.sv
module arb_next_state
  import arb_pkg::*;
(
  input  fav_e               fav,
  input  logic [GRANT_W-1:0] grant,
  output logic               upd_en,
  output fav_e               fav_nxt
);
  always_comb begin
    upd_en  = (grant != GNT_NONE);
    fav_nxt = fav;
    if (grant == GNT_Y)      fav_nxt = FAV_X;
    else if (grant == GNT_X) fav_nxt = FAV_Y;
  end
endmodule

// File: rtl/alt_prio_arbiter.sv
module alt_prio_arbiter
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_x,
  input  logic               req_y,
  output logic [GRANT_W-1:0] grant
);
  fav_e fav_q;
  fav_e fav_nxt;
  logic upd_en;

  arb_grant_decode u_dec (
    .fav   (fav_q),
    .req_x (req_x),
    .req_y (req_y),
    .grant (grant)
  );

  arb_next_state u_nxt (
    .fav     (fav_q),
    .grant   (grant),
    .upd_en  (upd_en),
    .fav_nxt (fav_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fav_q <= FAV_Y;
    else if (upd_en) fav_q <= fav_nxt;
  end

  // R8
  grant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant != 2'd3);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_x && !req_y) |=> $stable(fav_q));

  // R3
  lone_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_y && !req_x) |-> grant == 2'd1);

  // R4
  lone_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_x && !req_y) |-> grant == 2'd2);

  // R7
  hand_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'd1) |=> (!(req_x && req_y) || grant == 2'd2));

  // R7
  hand_to_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'd2) |=> (!(req_x && req_y) || grant == 2'd1));
endmodule

// File: tb/tb_alt_prio_arbiter.sv
module tb_alt_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_x = 1'b0;
  logic       req_y = 1'b0;
  logic [1:0] grant;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  alt_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_x(req_x), .req_y(req_y), .grant(grant)
  );

  // {req_x, req_y, expected grant}, walked from reset state favouring Y
  localparam logic [3:0] VEC [12] = '{
    4'b00_00, 4'b11_01, 4'b00_00, 4'b11_10,
    4'b10_10, 4'b11_01, 4'b01_01, 4'b11_10,
    4'b01_01, 4'b10_10, 4'b00_00, 4'b11_01
  };

  task automatic check(input logic [1:0] exp, input string tag);
    checks++;
    if (grant !== exp) begin
      failures++;
      $display("FAIL %s grant=%0d expected=%0d", tag, grant, exp);
    end
    checks++;
    if (grant === 2'd3) begin
      failures++;
      $display("FAIL R8 grant=%0d expected=not 3", grant);
    end
  endtask

  task automatic apply(input logic x, input logic y, input logic [1:0] exp,
                       input string tag);
    @(negedge clk);
    req_x = x;
    req_y = y;
    #1;
    check(exp, tag);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    req_x = 1'b1; req_y = 1'b1; #1;
    check(2'd1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    req_x = 1'b0; req_y = 1'b0;

    for (int i = 0; i < 12; i++) begin
      case (VEC[i][3:2])
        2'b00:   tag = "R2";
        2'b01:   tag = "R3";
        2'b10:   tag = "R4";
        default: tag = (VEC[i][1:0] == 2'd1) ? "R5" : "R6";
      endcase
      apply(VEC[i][3], VEC[i][2], VEC[i][1:0], tag);
    end

    // state now favours X; reset in the middle of the run
    @(negedge clk);
    rst_n = 1'b0;
    req_x = 1'b1; req_y = 1'b1;
    #1;
    check(2'd1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    req_x = 1'b0; req_y = 1'b0;
    apply(1'b1, 1'b1, 2'd1, "R1");

    // idle cycles leave the state favouring X
    apply(1'b0, 1'b0, 2'd0, "R2");
    apply(1'b0, 1'b0, 2'd0, "R2");
    apply(1'b1, 1'b1, 2'd2, "R2");

    // a lone Y grant moves the state to favour X
    apply(1'b0, 1'b1, 2'd1, "R7");
    apply(1'b1, 1'b1, 2'd2, "R7");

    // sustained ties alternate, starting from the state favouring Y
    for (int k = 0; k < 40; k++)
      apply(1'b1, 1'b1, (k % 2 == 0) ? 2'd1 : 2'd2, "R9");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule